// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with 16-bit registers. Software writes a control register to set an 8-bit timeout and arm the watchdog. From then on the block counts down by one on every half-second tick-enable pulse that arrives on an input. If the count runs out, the block drives a system reset output high for a fixed number of clock cycles. In the same cycle the watchdog returns itself to its reset state.

Software keeps the timer from expiring by writing a two-word key to a separate service register: first 0x5555, then 0xAAAA. Only this exact pair, in this order, reloads the count. Any other value written to the service register aborts a partly entered key. Once the watchdog is armed, software cannot disarm it. The clock that makes the half-second tick is outside the block.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `sys_rst_o` is 0 and the watchdog is disarmed with a timeout field of 0.
- R2: A write to offset 0x0 with bit 2 = 1 arms the watchdog, taking the timeout T from bits 15:8. `sys_rst_o` rises in the clock cycle after the (T+1)-th tick. T=0 gives 1 tick (0.5 s) and T=255 gives 256 ticks (128 s).
- R3: While the watchdog is disarmed, ticks have no effect and `sys_rst_o` stays 0.
- R4: Once armed, a control write with bit 2 = 0 does not disarm the watchdog. The running countdown continues.
- R5: On expiry, `sys_rst_o` is high for exactly PULSE_CYCLES (default 4) consecutive clock cycles.
- R6: Expiry returns the block to its reset state: disarmed, timeout 0, key sequence idle. No further pulse comes until the watchdog is armed again.
- R7: Writing 0x5555 and then 0xAAAA to offset 0x2 reloads the remaining count to T+1 ticks. T is the timeout field at the time of the 0xAAAA write. Other cycles may fall between the two writes.
- R8: Any service write that is not the next expected key resets the key sequence to waiting for 0x5555, without a reload. This includes 0xAAAA with no 0x5555 before it, a second 0x5555, and any other value.
- R9: If a completing 0xAAAA write falls in the same cycle as the tick that would expire the count, the reload wins. No pulse follows, and T+1 further ticks are needed.
- R10: Rewriting the timeout field while the watchdog is armed does not change the running count. The new value is used at the next reload.
- R11: Writes to offsets other than 0x0 and 0x2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (2) | Byte offset of the write |
| bus_wdata | input | 16 | Write data |
| half_sec_tick | input | 1 | One-cycle enable, once per half second |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
Two events can meet in a single cycle: the completing 0xAAAA service write and the tick that would take the count from 1 to expiry. The bench arms a short timeout and spends every tick but the last. It then issues the second key word with the tick input high in that same cycle. It judges the result by two things: `sys_rst_o` must stay low, and a fresh T+1 ticks must pass before the pulse appears. Seeded random trials vary the timeout, how many ticks pass before servicing, and stray writes to the service register.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int REG_W    = 16;
    localparam int TMO_W    = 8;
    localparam int TMO_LSB  = 8;
    localparam int ARM_BIT  = 2;
    localparam int CNT_W    = TMO_W + 1;

    localparam logic [REG_W-1:0] KEY_OPEN  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_CLOSE = 16'hAAAA;

    localparam int OFS_CTRL = 0;
    localparam int OFS_SVC  = 2;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             armed;
    } wdt_ctrl_t;

    typedef enum logic {
        KEY_WAIT_OPEN  = 1'b0,
        KEY_WAIT_CLOSE = 1'b1
    } key_state_e;

    function automatic logic [CNT_W-1:0] reload_count(input logic [TMO_W-1:0] tmo);
        return {1'b0, tmo} + CNT_W'(1);
    endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
`timescale 1ns/1ps
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             we,
    input  logic [TMO_W-1:0] tmo_in,
    input  logic             arm_in,
    output wdt_ctrl_t        ctrl_o,
    output logic             start_o
);
    wdt_ctrl_t ctrl_q;

    // arming edge: a write that sets the arm bit while disarmed
    assign start_o = we && arm_in && !ctrl_q.armed;
    assign ctrl_o  = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q.tmo   <= tmo_in;
            ctrl_q.armed <= ctrl_q.armed | arm_in;  // sticky once set
        end
    end
endmodule

// File: rtl/wdt_key_fsm.sv
`timescale 1ns/1ps
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             svc_we,
    input  logic [REG_W-1:0] wdata,
    output logic             reload_o,
    output key_state_e       state_o
);
    key_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        reload_o = 1'b0;
        if (svc_we) begin
            unique case (state_q)
                KEY_WAIT_OPEN: begin
                    state_d = (wdata == KEY_OPEN) ? KEY_WAIT_CLOSE : KEY_WAIT_OPEN;
                end
                KEY_WAIT_CLOSE: begin
                    reload_o = (wdata == KEY_CLOSE);
                    state_d  = KEY_WAIT_OPEN;
                end
                default: state_d = KEY_WAIT_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) state_q <= KEY_WAIT_OPEN;
        else              state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             armed,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // a reload in the same cycle as the final tick wins over expiry
    assign expire_o = armed && tick && !load && (cnt_q == CNT_W'(1));
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (armed && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse_o
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (fire)           left_q <= PW'(PULSE_CYCLES);
        else if (left_q != '0)   left_q <= left_q - PW'(1);
    end

    assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int ADDR_W       = 2,
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              half_sec_tick,
    output logic              sys_rst_o
);
    wdt_ctrl_t        ctrl;
    key_state_e       key_state;
    logic             ctrl_we, svc_we, start, key_reload, load, expire;
    logic [CNT_W-1:0] load_val, cnt;
    logic [TMO_W-1:0] tmo_wr;

    assign ctrl_we = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign svc_we  = bus_we && (bus_addr == ADDR_W'(OFS_SVC));
    assign tmo_wr  = bus_wdata[TMO_LSB +: TMO_W];

    wdt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .clear   (expire),
        .we      (ctrl_we),
        .tmo_in  (tmo_wr),
        .arm_in  (bus_wdata[ARM_BIT]),
        .ctrl_o  (ctrl),
        .start_o (start)
    );

    wdt_key_fsm u_key (
        .clk      (clk),
        .rst      (rst),
        .clear    (expire),
        .svc_we   (svc_we),
        .wdata    (bus_wdata),
        .reload_o (key_reload),
        .state_o  (key_state)
    );

    assign load     = start || (key_reload && ctrl.armed);
    assign load_val = start ? reload_count(tmo_wr) : reload_count(ctrl.tmo);

    wdt_countdown u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (expire),
        .armed    (ctrl.armed),
        .tick     (half_sec_tick),
        .load     (load),
        .load_val (load_val),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire    (expire),
        .pulse_o (sys_rst_o)
    );
endmodule

// File: rtl/wdt_keyed_chk.sv
`timescale 1ns/1ps
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sys_rst_o,
    input logic             armed,
    input logic             expire,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] cnt,
    input logic             svc_we,
    input logic [REG_W-1:0] wdata,
    input key_state_e       key_state
);
    logic [7:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)            hi_run <= '0;
        else if (sys_rst_o) hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 8'd1;
        else                hi_run <= '0;
    end

    // R5: the pulse never lasts longer than PULSE_CYCLES
    a_r5_pulse_max: assert property (@(posedge clk) disable iff (rst)
        hi_run <= 8'(PULSE_CYCLES));

    // R5: the pulse ends only after its full length
    a_r5_pulse_full: assert property (@(posedge clk) disable iff (rst)
        (hi_run != '0 && !sys_rst_o) |-> hi_run == 8'(PULSE_CYCLES));

    // R5: expiry starts the pulse on the next cycle
    a_r5_expire_starts_pulse: assert property (@(posedge clk) disable iff (rst)
        expire |=> sys_rst_o);

    // R4: armed only drops through expiry
    a_r4_armed_sticky: assert property (@(posedge clk) disable iff (rst)
        (armed && !expire) |=> armed);

    // R3: the count never grows except through a load
    a_r3_no_growth: assert property (@(posedge clk) disable iff (rst)
        !load |=> cnt <= $past(cnt));

    // R7: a load places the reload value in the counter
    a_r7_reload_value: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));

    // R8: a non-opening service write while waiting leaves the sequence waiting
    a_r8_bad_first_key: assert property (@(posedge clk) disable iff (rst)
        (svc_we && key_state == KEY_WAIT_OPEN && wdata != KEY_OPEN) |=> key_state == KEY_WAIT_OPEN);

    // R6: expiry disarms the watchdog
    a_r6_disarm_on_expiry: assert property (@(posedge clk) disable iff (rst)
        expire |=> !armed);
endmodule

bind wdt_keyed wdt_keyed_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sys_rst_o (sys_rst_o),
    .armed     (ctrl.armed),
    .expire    (expire),
    .load      (load),
    .load_val  (load_val),
    .cnt       (cnt),
    .svc_we    (svc_we),
    .wdata     (bus_wdata),
    .key_state (key_state)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;
    localparam int PULSE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        half_sec_tick = 1'b0;
    logic        sys_rst_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    wdt_keyed #(.ADDR_W(2), .PULSE_CYCLES(PULSE)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .half_sec_tick (half_sec_tick),
        .sys_rst_o     (sys_rst_o)
    );

    function automatic int expect_ticks(input int tmo);
        return tmo + 1;
    endfunction

    function automatic logic [15:0] ctrl_word(input int tmo, input bit arm);
        return {8'(tmo), 5'b0, arm, 2'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input bit with_tick);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; half_sec_tick = with_tick;
        @(negedge clk);
        bus_we = 1'b0; half_sec_tick = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        half_sec_tick = 1'b1;
        @(negedge clk);
        half_sec_tick = 1'b0;
    endtask

    // ticks that must not expire; returns how many saw sys_rst_o high
    task automatic quiet_ticks(input int k, output int seen);
        seen = 0;
        for (int i = 0; i < k; i++) begin
            do_tick();
            if (sys_rst_o) seen++;
        end
    endtask

    task automatic measure(input int max, output int n);
        n = -1;
        for (int i = 1; i <= max; i++) begin
            do_tick();
            if (sys_rst_o) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic pulse_len(output int len);
        len = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!sys_rst_o) break;
            len++;
        end
    endtask

    task automatic service();
        bus_write(2'd2, 16'h5555, 1'b0);
        bus_write(2'd2, 16'hAAAA, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0 (run hung)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n, seen, len, seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(sys_rst_o == 1'b0, "R1 reset output", int'(sys_rst_o), 0);

        // R3: disarmed ticks do nothing
        quiet_ticks(300, seen);
        check(seen == 0, "R3 disarmed ticks", seen, 0);

        // R2: shortest timeout
        bus_write(2'd0, ctrl_word(0, 1), 1'b0);
        measure(5, n);
        check(n == expect_ticks(0), "R2 timeout 0", n, expect_ticks(0));
        pulse_len(len);
        check(len == PULSE, "R5 pulse length", len, PULSE);

        // R6: back to reset state
        quiet_ticks(300, seen);
        check(seen == 0, "R6 no pulse after expiry", seen, 0);

        // R2: longest timeout
        bus_write(2'd0, ctrl_word(255, 1), 1'b0);
        measure(300, n);
        check(n == expect_ticks(255), "R2 timeout 255", n, expect_ticks(255));
        pulse_len(len);
        check(len == PULSE, "R5 pulse length long", len, PULSE);

        // R6: timeout field cleared by expiry: a service on a rearm with T=1 uses 1
        bus_write(2'd0, ctrl_word(1, 1), 1'b0);
        measure(10, n);
        check(n == 2, "R6 rearm after expiry", n, 2);
        pulse_len(len);

        // R4: arm bit sticky
        bus_write(2'd0, ctrl_word(2, 1), 1'b0);
        bus_write(2'd0, ctrl_word(0, 0), 1'b0);
        measure(10, n);
        check(n == expect_ticks(2), "R4 disarm ignored", n, expect_ticks(2));
        pulse_len(len);

        // R7: valid service reloads
        bus_write(2'd0, ctrl_word(5, 1), 1'b0);
        quiet_ticks(3, seen);
        check(seen == 0, "R7 early ticks", seen, 0);
        service();
        measure(20, n);
        check(n == expect_ticks(5), "R7 reload after key", n, expect_ticks(5));
        pulse_len(len);

        // R8: broken sequences do not reload
        bus_write(2'd0, ctrl_word(4, 1), 1'b0);
        quiet_ticks(2, seen);
        bus_write(2'd2, 16'h5555, 1'b0);
        bus_write(2'd2, 16'h1234, 1'b0);
        bus_write(2'd2, 16'hAAAA, 1'b0);
        bus_write(2'd2, 16'hAAAA, 1'b0);
        bus_write(2'd2, 16'h5555, 1'b0);
        bus_write(2'd2, 16'h5555, 1'b0);
        bus_write(2'd2, 16'h0000, 1'b0);
        bus_write(2'd2, 16'hAAAA, 1'b0);
        measure(20, n);
        check(n == 3, "R8 bad keys no reload", n, 3);
        pulse_len(len);

        // R11: unmapped offsets ignored
        bus_write(2'd0, ctrl_word(4, 1), 1'b0);
        quiet_ticks(2, seen);
        bus_write(2'd1, 16'h5555, 1'b0);
        bus_write(2'd3, 16'hAAAA, 1'b0);
        bus_write(2'd3, 16'h5555, 1'b0);
        bus_write(2'd1, 16'hAAAA, 1'b0);
        bus_write(2'd1, ctrl_word(0, 0), 1'b0);
        measure(20, n);
        check(n == 3, "R11 unmapped writes", n, 3);
        pulse_len(len);

        // R9: completing key in the same cycle as the last tick
        bus_write(2'd0, ctrl_word(3, 1), 1'b0);
        quiet_ticks(3, seen);
        bus_write(2'd2, 16'h5555, 1'b0);
        bus_write(2'd2, 16'hAAAA, 1'b1);
        check(sys_rst_o == 1'b0, "R9 collision no pulse", int'(sys_rst_o), 0);
        measure(20, n);
        check(n == expect_ticks(3), "R9 collision reload", n, expect_ticks(3));
        pulse_len(len);

        // R10: timeout rewrite applies at next reload
        bus_write(2'd0, ctrl_word(2, 1), 1'b0);
        bus_write(2'd0, ctrl_word(7, 1), 1'b0);
        quiet_ticks(2, seen);
        check(seen == 0, "R10 count unchanged", seen, 0);
        service();
        measure(20, n);
        check(n == expect_ticks(7), "R10 new timeout at reload", n, expect_ticks(7));
        pulse_len(len);

        // random trials: R2 R7 R8
        for (int t = 0; t < 24; t++) begin
            int tmo, k, noise;
            tmo   = int'($urandom_range(0, 20));
            k     = int'($urandom_range(0, tmo));
            noise = int'($urandom_range(0, 3));
            bus_write(2'd0, ctrl_word(tmo, 1), 1'b0);
            quiet_ticks(k, seen);
            check(seen == 0, "R2 random early", seen, 0);
            for (int j = 0; j < noise; j++)
                bus_write(2'd2, 16'($urandom_range(0, 16'h5554)), 1'b0);
            if (t % 2 == 0) begin
                service();
                measure(40, n);
                check(n == expect_ticks(tmo), "R7 random service", n, expect_ticks(tmo));
            end else begin
                bus_write(2'd2, 16'hAAAA, 1'b0);
                measure(40, n);
                check(n == expect_ticks(tmo) - k, "R8 random lone close key", n, expect_ticks(tmo) - k);
            end
            pulse_len(len);
            check(len == PULSE, "R5 random pulse", len, PULSE);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule